// File: doc/BRIEF.md
# Memory-to-UART Hexadecimal Dump Sequencer

This block turns a captured frame of 16-bit samples into readable terminal text. It sits between the read port of a dual-port memory and a byte-wide serial transmitter. Once the capture side reports that the memory holds a complete frame, the block reads the words one after another from address 0. For each word it sends four uppercase hexadecimal characters, most significant nibble first, followed by a line-feed byte. After the last word it sends a second line feed, so a blank line separates one dump from the next. It then returns to address 0 and starts again for as long as the frame-ready input stays high.

The sequencer waits for the transmitter to report idle before it offers each byte. It raises a one-cycle send strobe with the byte and then allows one settle cycle, so that the transmitter can raise its busy flag. The memory is assumed to return data one cycle after the address is presented. The serial bit engine and any receive path live outside this block.

Top module: `hexdump_seq`

## Requirements
- R1: While reset is asserted, `tx_strobe` is low and `rd_addr` is 0. After reset, no byte is sent until `frame_ready` is seen high while the block is idle.
- R2: A dump reads addresses in ascending order from 0 to DEPTH-1. The address changes only by an increment of one or a return to 0, and it is 0 whenever the block is idle.
- R3: Each word is sent as four characters, starting with bits [15:12] and ending with bits [3:0].
- R4: Nibble values 0 to 9 are sent as bytes 0x30 to 0x39, and values 10 to 15 as bytes 0x41 to 0x46 (uppercase A to F).
- R5: A line-feed byte 0x0A follows the fourth character of every word, and the next word is read only after it.
- R6: After the line feed of the last word, one extra 0x0A is sent. The block then restarts at address 0 if `frame_ready` is high, and otherwise stays idle and sends nothing.
- R7: `tx_strobe` is asserted only in a cycle in which `tx_busy` is low.
- R8: `tx_strobe` is a single-cycle pulse and is never high in two consecutive cycles. The transmitter must raise `tx_busy` in the cycle after a strobe.
- R9: `rd_data` is taken one clock after `rd_addr` is presented. The word that is sent is the memory content at that address, with no stale or skipped word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_ready | input | 1 | High while memory holds a complete frame and capture has stopped |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | WORD_W | Memory read data, valid one cycle after the address |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_strobe | output | 1 | One-cycle send request for `tx_byte` |
| tx_busy | input | 1 | Transmitter is still sending the previous byte |

## Verification
Two events can meet in one cycle: the transmitter releasing busy, and the sequencer arriving in a sending state. If busy lasts only one cycle, the strobe is due right after the settle cycle. The bench provokes this with directed one-cycle busy periods and then with random lengths from 1 to 6 cycles, and it flags any strobe raised while busy or on back-to-back cycles. The second meeting is the fall of `frame_ready` just as the blank-line byte is sent. The bench drops it at that point and expects silence, with the address parked at 0.

// File: rtl/hexdump_pkg.sv
package hexdump_pkg;

  localparam logic [7:0] LINE_FEED = 8'h0A;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_HEX,
    ST_HEX_GAP,
    ST_EOL,
    ST_EOL_GAP,
    ST_BLANK,
    ST_BLANK_GAP
  } seq_state_t;

endpackage

// File: rtl/hd_nibble_enc.sv
module hd_nibble_enc (
  input  logic [3:0] nib,
  output logic [7:0] ascii
);

  logic is_digit;

  always_comb begin
    is_digit = (nib < 4'd10);
    if (is_digit) begin
      ascii = 8'h30 + {4'h0, nib};
    end else begin
      ascii = 8'h37 + {4'h0, nib};
    end
  end

endmodule

// File: rtl/hd_word_shifter.sv
module hd_word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] din,
  output logic [3:0]        top_nib,
  output logic              all_sent
);

  localparam int NIBBLES = WORD_W / 4;
  localparam int CNT_W   = $clog2(NIBBLES + 1);

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (load_en) begin
      sreg_d = din;
      cnt_d  = '0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[WORD_W-5:0], 4'h0};
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_en || shift_en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end

  assign top_nib  = sreg_q[WORD_W-1 -: 4];
  assign all_sent = (cnt_q == CNT_W'(NIBBLES));

endmodule

// File: rtl/hd_addr_ptr.sv
module hd_addr_ptr #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              inc_en,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr_en) begin
      addr_d = '0;
    end else if (inc_en) begin
      addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (clr_en || inc_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == LAST_ADDR);

endmodule

// File: rtl/hexdump_seq.sv
module hexdump_seq #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe,
  input  logic              tx_busy
);

  import hexdump_pkg::*;

  seq_state_t state_q, state_d;

  logic       load_en, shift_en, clr_en, inc_en;
  logic [3:0] top_nib;
  logic       all_sent, at_last;
  logic [7:0] hex_char;

  hd_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .shift_en (shift_en),
    .din      (rd_data),
    .top_nib  (top_nib),
    .all_sent (all_sent)
  );

  hd_addr_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_en),
    .inc_en  (inc_en),
    .addr    (rd_addr),
    .at_last (at_last)
  );

  hd_nibble_enc u_enc (
    .nib   (top_nib),
    .ascii (hex_char)
  );

  // next-state and control decode
  always_comb begin
    state_d   = state_q;
    load_en   = 1'b0;
    shift_en  = 1'b0;
    clr_en    = 1'b0;
    inc_en    = 1'b0;
    tx_strobe = 1'b0;
    tx_byte   = LINE_FEED;
    unique case (state_q)
      ST_IDLE: begin
        clr_en = 1'b1;
        if (frame_ready) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        load_en = 1'b1;
        state_d = ST_HEX;
      end
      ST_HEX: begin
        tx_byte = hex_char;
        if (!tx_busy) begin
          tx_strobe = 1'b1;
          shift_en  = 1'b1;
          state_d   = ST_HEX_GAP;
        end
      end
      ST_HEX_GAP: begin
        state_d = all_sent ? ST_EOL : ST_HEX;
      end
      ST_EOL: begin
        if (!tx_busy) begin
          tx_strobe = 1'b1;
          state_d   = ST_EOL_GAP;
        end
      end
      ST_EOL_GAP: begin
        if (at_last) begin
          state_d = ST_BLANK;
        end else begin
          inc_en  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_BLANK: begin
        if (!tx_busy) begin
          tx_strobe = 1'b1;
          state_d   = ST_BLANK_GAP;
        end
      end
      ST_BLANK_GAP: begin
        clr_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/hexdump_chk.sv
module hexdump_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        tx_byte,
  input logic              tx_strobe,
  input logic              tx_busy
);

  p_strobe_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> !tx_busy);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);

  p_char_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> ((tx_byte >= 8'h30 && tx_byte <= 8'h39) ||
                   (tx_byte >= 8'h41 && tx_byte <= 8'h46) ||
                   (tx_byte == 8'h0A)));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != $past(rd_addr)) |->
      (rd_addr == $past(rd_addr) + ADDR_W'(1) || rd_addr == '0));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr <= ADDR_W'(DEPTH - 1));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe && tx_byte != 8'h0A |=> $stable(rd_addr));

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!tx_strobe);
    end
  end

endmodule

bind hexdump_seq hexdump_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_addr   (rd_addr),
  .tx_byte   (tx_byte),
  .tx_strobe (tx_strobe),
  .tx_busy   (tx_busy)
);

// File: tb/tb_hexdump_seq.sv
module tb_hexdump_seq;

  localparam int DEPTH    = 8;
  localparam int AW       = 3;
  localparam int DUMP_LEN = DEPTH * 5 + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_ready;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data;
  logic [7:0]    tx_byte;
  logic          tx_strobe;
  logic          tx_busy;

  logic [15:0] mem [DEPTH];
  int checks = 0, fails = 0, pos = 0, nbytes = 0;
  int busy_min = 1, busy_span = 1, busy_cnt = 0;
  bit prev_strobe = 1'b0;

  always #5 clk = ~clk;

  hexdump_seq #(.DEPTH(DEPTH), .ADDR_W(AW), .WORD_W(16)) dut (
    .clk (clk), .rst_n (rst_n), .frame_ready (frame_ready),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .tx_byte (tx_byte), .tx_strobe (tx_strobe), .tx_busy (tx_busy)
  );

  // memory model: one cycle read latency
  always @(posedge clk) rd_data <= mem[rd_addr];

  // transmitter model: busy rises after a strobe, lasts a random length
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      busy_cnt <= 0;
    end else if (tx_strobe) begin
      tx_busy  <= 1'b1;
      busy_cnt <= busy_min + int'($urandom % busy_span);
    end else if (tx_busy) begin
      if (busy_cnt <= 1) tx_busy <= 1'b0;
      busy_cnt <= busy_cnt - 1;
    end
  end

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
  endfunction

  function automatic logic [7:0] exp_byte(input int p);
    int w, k;
    if (p == DEPTH * 5) return 8'h0A;
    w = p / 5;
    k = p % 5;
    if (k == 4) return 8'h0A;
    return hexch(mem[w][15 - 4*k -: 4]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // byte monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && tx_strobe) begin
      string req;
      req = (pos == DEPTH*5) ? "R6" : ((pos % 5 == 4) ? "R5" : "R3/R4/R9");
      chk(!tx_busy, "R7 strobe while busy", int'(tx_busy), 0);
      chk(!prev_strobe, "R8 back-to-back strobe", 1, 0);
      chk(tx_byte == exp_byte(pos), req, int'(tx_byte), int'(exp_byte(pos)));
      pos = (pos + 1) % DUMP_LEN;
      nbytes++;
    end
    prev_strobe = tx_strobe;
  end

  task automatic wait_bytes(input int target);
    int t = 0;
    while (nbytes < target && t < 30000) begin
      @(negedge clk); #1;
      t++;
    end
    if (t >= 30000) chk(1'b0, "watchdog byte wait", nbytes, target);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog global", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    frame_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(tx_strobe == 1'b0, "R1 reset strobe", int'(tx_strobe), 0);
    chk(rd_addr == '0, "R1 reset address", int'(rd_addr), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(nbytes == 0, "R1 silent without frame_ready", nbytes, 0);

    // directed: digit/letter boundaries, all-zero, all-one words
    mem[0] = 16'h0000; mem[1] = 16'hFFFF; mem[2] = 16'h09AF; mem[3] = 16'hA5F0;
    mem[4] = 16'h1234; mem[5] = 16'h8000; mem[6] = 16'h0001; mem[7] = 16'hBEEF;
    busy_min = 1; busy_span = 1;
    pos = 0;
    frame_ready = 1'b1;
    // R6: three back-to-back dumps, then drop frame_ready on the blank line
    wait_bytes(3 * DUMP_LEN);
    frame_ready = 1'b0;
    repeat (60) @(negedge clk);
    chk(nbytes == 3 * DUMP_LEN, "R6 idle after blank line", nbytes, 3 * DUMP_LEN);
    chk(pos == 0, "R6 dump ended on blank line", pos, 0);
    chk(rd_addr == '0, "R2 address parked at 0", int'(rd_addr), 0);

    // random rounds with random busy lengths
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 16'($urandom);
      busy_min = 1; busy_span = 6;
      pos = 0;
      base = nbytes;
      frame_ready = 1'b1;
      @(negedge clk);
      if (r == 4) frame_ready = 1'b0;  // one-cycle frame_ready pulse
      wait_bytes(base + DUMP_LEN);
      frame_ready = 1'b0;
      repeat (60) @(negedge clk);
      chk(nbytes == base + DUMP_LEN, "R6 one dump per round", nbytes - base, DUMP_LEN);
      chk(rd_addr == '0, "R2 address back at 0", int'(rd_addr), 0);
    end

    finish_run();
  end

endmodule